// File: doc/BRIEF.md
# Channel Read-Data Domain Delay Aligner

This block sits at the transmit side of a device on a multi-drop memory channel. The channel's end-to-end propagation delay spans several clock cycles. The channel is cut into timing domains of one clock period each. A device close to the master would return read data earlier than a distant one. Software gives each device a coarse delay, counted in whole cycles, that matches its domain. The aligner then holds every outgoing transfer back by that many cycles, so that returns from all devices reach the master on the same cycle.

Software loads the delay, together with an enable bit, through a one-cycle configuration write. Each packet of up to eight transfers is marked by a start strobe on its first transfer. The delay in force at that start is latched, and every transfer of the packet uses it. This keeps a packet whole even when the setting is rewritten while the packet is in flight. Packets may follow one another with no idle cycle between them. Each output transfer carries its own valid flag, delayed exactly like its data.

Top module: `chan_domain_aligner`

## Requirements
- R1: A synchronous reset empties the delay line, holds out_valid low, and sets the stored delay to 0 and the enable bit to 0. After reset and before any configuration write, data passes with the minimum latency of R2.
- R2: With the aligner enabled and effective delay D (0 to 7), a transfer presented with in_valid high in cycle t appears on out_valid/out_data in cycle t+1+D.
- R3: A cycle with cfg_wr_en high stores cfg_delay and cfg_enable. The stored values govern packets that start in later cycles.
- R4: While the stored enable bit is 0, the effective delay is 0 whatever delay value is stored.
- R5: The effective delay is latched on a transfer with pkt_start and in_valid both high. Later transfers without pkt_start keep that delay, even if a configuration write occurs mid-packet.
- R6: A packet whose first transfer coincides with a configuration write uses the setting from before the write.
- R7: Packets of 1 to 8 transfers sent back to back with equal delay leave in order, with no transfer lost and no gap added.
- R8: out_data is all zeros whenever out_valid is low. in_data has no effect in cycles where in_valid is low.
- R9: pkt_start asserted while in_valid is low is ignored, and the delay in force does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable bit written with the delay |
| cfg_delay | input | DLY_W | Coarse delay in cycles |
| pkt_start | input | 1 | Marks the first transfer of a packet |
| in_valid | input | 1 | Input transfer valid |
| in_data | input | DATA_W | Input transfer data |
| out_valid | output | 1 | Delayed transfer valid |
| out_data | output | DATA_W | Delayed transfer data |

## Verification
The bench uses the default parameters: an 18-bit transfer and a 3-bit delay field, which gives eight delay settings. This small space lets the bench cover every delay setting with every packet length from 1 to 8, sent back to back. The expected output cycle of each transfer is computed arithmetically from the bench's own model of the latched delay. Mid-packet writes, same-cycle writes, stray start strobes and a reset taken with packets in flight are each placed at known cycles.

// File: rtl/chan_align_pkg.sv
package chan_align_pkg;
    // Default transfer width and delay-field width for the aligner
    localparam int unsigned ALIGN_DATA_W = 18;
    localparam int unsigned ALIGN_DLY_W  = 3;
endpackage

// File: rtl/align_cfg_ctrl.sv
module align_cfg_ctrl #(
    parameter int unsigned DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic             cfg_enable,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             pkt_start,
    input  logic             in_valid,
    output logic [DLY_W-1:0] act_dly
);
    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             en;
        logic [DLY_W-1:0] act;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic             start_w;
    logic [DLY_W-1:0] eff_w;

    always_comb begin
        start_w = in_valid & pkt_start;
        eff_w   = s_q.en ? s_q.dly : '0;
        s_d     = s_q;
        if (start_w) begin
            s_d.act = eff_w;
        end
        if (cfg_wr_en) begin
            s_d.dly = cfg_delay;
            s_d.en  = cfg_enable;
        end
        if (rst) begin
            s_d = '0;
        end
        act_dly = start_w ? eff_w : s_q.act;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // R1: reset returns all configuration state to zero
    assert_cfg_reset_R1: assert property (@(posedge clk) rst |=> (s_q == '0));

    // R5, R9: latched delay only moves on a valid packet start
    assert_act_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && pkt_start) |=> $stable(s_q.act));

    // R4: disabled aligner latches a zero delay
    assert_disabled_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (!s_q.en && in_valid && pkt_start) |=> (s_q.act == '0));
endmodule

// File: rtl/align_tap_line.sv
module align_tap_line #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DLY_W-1:0]  wr_tap,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned DEPTH = 2 ** DLY_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t [DEPTH-1:0] line_d, line_q;
    slot_t [DEPTH-1:0] upper_w;

    // Source each slot shifts from: the next slot up, or empty at the top
    for (genvar g = 0; g < DEPTH; g++) begin : g_upper
        if (g == DEPTH - 1) begin : g_top
            assign upper_w[g] = '0;
        end else begin : g_mid
            assign upper_w[g] = line_q[g+1];
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_valid && (wr_tap == DLY_W'(i))) begin
                line_d[i] = '{vld: 1'b1, data: wr_data};
            end else begin
                line_d[i] = upper_w[i];
            end
        end
        if (rst) begin
            line_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        line_q <= line_d;
    end

    assign out_valid = line_q[0].vld;
    assign out_data  = line_q[0].data;

    // R2: a zero-delay write is visible one cycle later, unchanged
    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_tap == '0) |=> (out_valid && out_data == $past(wr_data)));

    // R8: idle output carries no data
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));
endmodule

// File: rtl/chan_domain_aligner.sv
module chan_domain_aligner #(
    parameter int unsigned DATA_W = chan_align_pkg::ALIGN_DATA_W,
    parameter int unsigned DLY_W  = chan_align_pkg::ALIGN_DLY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_enable,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              pkt_start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DLY_W-1:0] act_dly_w;

    align_cfg_ctrl #(.DLY_W(DLY_W)) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_enable (cfg_enable),
        .cfg_delay  (cfg_delay),
        .pkt_start  (pkt_start),
        .in_valid   (in_valid),
        .act_dly    (act_dly_w)
    );

    align_tap_line #(.DATA_W(DATA_W), .DLY_W(DLY_W)) line_i (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (in_valid),
        .wr_data   (in_data),
        .wr_tap    (act_dly_w),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R1: output goes quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/chan_domain_aligner_tb_top.sv
module chan_domain_aligner_tb_top;
    localparam int DW = 18;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [LW-1:0] cfg_delay = '0;
    logic          pkt_start = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    chan_domain_aligner dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_enable(cfg_enable),
        .cfg_delay(cfg_delay), .pkt_start(pkt_start), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    int wd_cnt = 0;
    string tag = "R1";

    // bench model
    logic          ev [64];
    logic [DW-1:0] ed [64];
    int            m_dly = 0;
    logic          m_en = 1'b0;
    int            m_act = 0;

    task automatic clear_model();
        for (int k = 0; k < 64; k++) begin
            ev[k] = 1'b0;
            ed[k] = '0;
        end
        m_dly = 0; m_en = 1'b0; m_act = 0;
    endtask

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s edge %0d actual %0h expected %0h", t, edge_n, act, exp);
        end
    endtask

    // one clock: inputs already driven; model at posedge, compare at negedge
    task automatic cycle();
        int a;
        int eff;
        @(posedge clk);
        edge_n++;
        if (rst) begin
            clear_model();
        end else begin
            eff = m_en ? m_dly : 0;
            if (in_valid) begin
                a = pkt_start ? eff : m_act;
                m_act = a;
                ev[(edge_n + a) % 64] = 1'b1;
                ed[(edge_n + a) % 64] = in_data;
            end
            if (cfg_wr_en) begin
                m_dly = int'(cfg_delay);
                m_en  = cfg_enable;
            end
        end
        @(negedge clk);
        chk(out_valid == ev[edge_n % 64], tag, int'(out_valid), int'(ev[edge_n % 64]));
        chk(out_data == ed[edge_n % 64], tag, int'(out_data), int'(ed[edge_n % 64]));
        ev[edge_n % 64] = 1'b0;
        ed[edge_n % 64] = '0;
    endtask

    task automatic drive(input bit v, input bit s, input int d,
                         input bit w, input int wd, input bit wen);
        in_valid   = v;
        pkt_start  = s;
        in_data    = DW'(d);
        cfg_wr_en  = w;
        cfg_delay  = LW'(wd);
        cfg_enable = wen;
        cycle();
    endtask

    task automatic idle(input int n);
        // R8: garbage on in_data while in_valid is low must not show
        for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 18'h2A5A5 ^ k, 1'b0, 0, 1'b0);
    endtask

    task automatic write_cfg(input int d, input bit en);
        drive(1'b0, 1'b0, 0, 1'b1, d, en);
    endtask

    task automatic send_pkt(input int len, input int base);
        for (int k = 0; k < len; k++) drive(1'b1, k == 0, base + k, 1'b0, 0, 1'b0);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        // R1: reset state
        tag = "R1";
        rst = 1'b1;
        for (int k = 0; k < 3; k++) cycle();
        rst = 1'b0;
        idle(2);
        // R1: default delay 0 before any write
        send_pkt(4, 18'h100);
        idle(4);

        // R2 R7: every delay with every packet length, back to back
        tag = "R2 R7";
        for (int d = 0; d < 8; d++) begin
            write_cfg(d, 1'b1);
            idle(1);
            for (int len = 1; len <= 8; len++) send_pkt(len, (d << 12) + (len << 4));
            idle(10);
        end

        // R4: disabled aligner ignores stored delay
        tag = "R4";
        write_cfg(6, 1'b0);
        send_pkt(5, 18'h3F000);
        send_pkt(3, 18'h3F100);
        idle(10);

        // R3 R5: write mid-packet, packet keeps old delay, next uses new
        tag = "R5";
        write_cfg(2, 1'b1);
        for (int k = 0; k < 8; k++)
            drive(1'b1, k == 0, 18'h01200 + k, k == 3, 5, 1'b1);
        idle(10);
        tag = "R3";
        send_pkt(6, 18'h01300);
        idle(10);

        // R6: write coincides with a packet start
        tag = "R6";
        write_cfg(1, 1'b1);
        drive(1'b1, 1'b1, 18'h01400, 1'b1, 6, 1'b1);
        for (int k = 1; k < 4; k++) drive(1'b1, 1'b0, 18'h01400 + k, 1'b0, 0, 1'b0);
        idle(10);
        send_pkt(4, 18'h01500);
        idle(10);

        // R9: start strobe without valid is ignored
        tag = "R9";
        write_cfg(3, 1'b1);
        drive(1'b1, 1'b1, 18'h01600, 1'b0, 0, 1'b0);
        drive(1'b1, 1'b0, 18'h01601, 1'b1, 7, 1'b1);
        drive(1'b0, 1'b1, 18'h3FFFF, 1'b0, 0, 1'b0);
        drive(1'b1, 1'b0, 18'h01602, 1'b0, 0, 1'b0);
        drive(1'b1, 1'b0, 18'h01603, 1'b0, 0, 1'b0);
        idle(12);

        // R8: gapped valid reproduced, idle data stays zero
        tag = "R8";
        write_cfg(4, 1'b1);
        for (int k = 0; k < 8; k++) drive(k % 3 != 2, k == 0, 18'h01700 + k, 1'b0, 0, 1'b0);
        idle(10);

        // R1: reset with packets in flight
        tag = "R1";
        write_cfg(7, 1'b1);
        send_pkt(4, 18'h01800);
        rst = 1'b1;
        for (int k = 0; k < 2; k++) drive(1'b1, 1'b1, 18'h01900, 1'b1, 5, 1'b1);
        rst = 1'b0;
        idle(10);
        send_pkt(3, 18'h01A00);
        idle(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule